// File: doc/BRIEF.md
# Heartbeat Interval Supervisor

This block runs inside one node of a daisy-chained set of devices. It keeps the link alive by asking the neighbouring tone codec for a heartbeat tone at a fixed interval. It also watches the heartbeats arriving from the other side. If they stop for too long, it raises a sticky timeout flag. If two of them arrive closer together than a minimum spacing, it raises a sticky too-fast flag. Producing and detecting the tone pulses is left to the codec.

All timing is counted in ticks of a 1 ms strobe. Counters are 11 bits wide and saturate instead of wrapping. When a fault is reported, the node stops sending heartbeats and sends fault tones instead. The first fault tone goes out at fault onset and the next ones follow at a fixed retry interval for as long as the fault lasts. Dropping the enable returns every interval counter to its start point but leaves the flags as they are. Only the clear input lowers a flag.

Top module: `hb_supervisor`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, all four outputs are 0.
- R2: While enabled and with no fault, `hb_send_req` is a one-cycle pulse. It is issued on the 400th tick after enable (or after fault release), and then on every 400th tick.
- R3: `timeout_flag` sets when 1000 ticks pass without a heartbeat. The count starts at enable or at the last received heartbeat. A heartbeat in the same cycle as the 1000th tick cancels the timeout.
- R4: `too_fast_flag` sets when a received heartbeat follows the previous one after fewer than 200 ticks. A spacing of exactly 200 ticks is accepted.
- R5: The first heartbeat received after enable only arms the spacing check and never sets `too_fast_flag`.
- R6: While `fault_present` is high, `hb_send_req` stays 0. The send interval restarts from zero when the fault goes away.
- R7: While enabled with a fault, `fault_tone_req` pulses in the cycle after the fault appears. It then pulses on every 50th tick after that.
- R8: Both flags hold until `flag_clear` is pulsed. When a set event and a clear fall in the same cycle, the flag stays set.
- R9: While `enable` is low, no requests are issued, the flags keep their value and every interval counter is reset.
- R10: Interval counters saturate at 2047. One silent gap therefore produces exactly one timeout event, and the flag stays low after a clear, even past 3048 silent ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1ms | input | 1 | One-cycle strobe, once per millisecond |
| enable | input | 1 | Supervisor enable |
| fault_present | input | 1 | Level: a fault condition is active |
| hb_detected | input | 1 | One-cycle strobe: heartbeat tone received |
| flag_clear | input | 1 | One-cycle pulse clearing both flags |
| hb_send_req | output | 1 | Request to the codec to send a heartbeat tone |
| fault_tone_req | output | 1 | Request to the codec to send a fault tone |
| timeout_flag | output | 1 | Sticky: heartbeats stopped too long |
| too_fast_flag | output | 1 | Sticky: heartbeats arrived too close together |

## Verification
The bench places received heartbeats exactly 199 and 200 ticks apart. A design with an off-by-one comparison would flag the legal spacing or miss the illegal one. A long silent gap of more than 3000 ticks, with a clear after the first timeout, exposes a counter that wraps: it would raise the timeout a second time. A set and a clear in the same cycle catch a flag in which the clear wins. Fault episodes with counted tone and heartbeat requests catch a design that keeps sending heartbeats during a fault, skips the tone at onset, or does not restart the send interval after release.

// File: rtl/hb_pkg.sv
package hb_pkg;
  parameter int unsigned HB_CNT_W = 11;
  typedef logic [HB_CNT_W-1:0] ms_cnt_t;
  localparam ms_cnt_t MS_CNT_MAX = '1;

  // saturating increment of a millisecond counter
  function automatic ms_cnt_t ms_sat_inc(input ms_cnt_t c);
    return (c == MS_CNT_MAX) ? c : c + 1'b1;
  endfunction

  // true when the counter sits on the last value before lim_ms elapses
  function automatic logic ms_at_limit(input ms_cnt_t c, input int unsigned lim_ms);
    return c == ms_cnt_t'(lim_ms - 1);
  endfunction

  // true when fewer than lim_ms ticks have been counted
  function automatic logic ms_below(input ms_cnt_t c, input int unsigned lim_ms);
    return 32'(c) < lim_ms;
  endfunction
endpackage

// File: rtl/hb_tx_sched.sv
module hb_tx_sched
  import hb_pkg::*;
#(
  parameter int unsigned SEND_MS  = 400,
  parameter int unsigned RETRY_MS = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic enable,
  input  logic fault,
  output logic send_req,
  output logic tone_req
);
  ms_cnt_t send_cnt;
  ms_cnt_t retry_cnt;
  logic    fault_q;

  logic send_live, fault_live, fault_onset, send_due, retry_due;

  assign send_live   = enable & ~fault;
  assign fault_live  = enable & fault;
  assign fault_onset = fault_live & ~fault_q;
  assign send_due    = send_live & tick & ms_at_limit(send_cnt, SEND_MS);
  assign retry_due   = fault_live & ~fault_onset & tick & ms_at_limit(retry_cnt, RETRY_MS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      send_cnt  <= '0;
      retry_cnt <= '0;
      fault_q   <= 1'b0;
      send_req  <= 1'b0;
      tone_req  <= 1'b0;
    end else begin
      fault_q  <= fault_live;
      send_req <= send_due;
      tone_req <= fault_onset | retry_due;

      if (!send_live)
        send_cnt <= '0;
      else if (tick)
        send_cnt <= send_due ? '0 : ms_sat_inc(send_cnt);

      if (!fault_live || fault_onset)
        retry_cnt <= '0;
      else if (tick)
        retry_cnt <= retry_due ? '0 : ms_sat_inc(retry_cnt);
    end
  end

  assert_send_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    send_req |=> !send_req);
  assert_send_no_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
    send_req |-> $past(send_live));
  assert_req_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(send_req && tone_req));
  assert_tone_in_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tone_req |-> $past(fault_live));
endmodule

// File: rtl/hb_rx_monitor.sv
module hb_rx_monitor
  import hb_pkg::*;
#(
  parameter int unsigned TIMEOUT_MS = 1000,
  parameter int unsigned FAST_MS    = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic enable,
  input  logic hb_seen,
  output logic timeout_event,
  output logic fast_event
);
  ms_cnt_t gap_cnt;
  logic    armed_q;

  // a received heartbeat has priority over a tick in the same cycle
  assign fast_event    = enable & hb_seen & armed_q & ms_below(gap_cnt, FAST_MS);
  assign timeout_event = enable & ~hb_seen & tick & ms_at_limit(gap_cnt, TIMEOUT_MS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_cnt <= '0;
      armed_q <= 1'b0;
    end else if (!enable) begin
      gap_cnt <= '0;
      armed_q <= 1'b0;
    end else if (hb_seen) begin
      gap_cnt <= '0;
      armed_q <= 1'b1;
    end else if (tick) begin
      gap_cnt <= ms_sat_inc(gap_cnt);
    end
  end

  assert_gap_saturates_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !hb_seen && tick && gap_cnt == MS_CNT_MAX) |=> gap_cnt == MS_CNT_MAX);
  assert_timeout_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_event |=> !timeout_event);
  assert_hb_rearms_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && hb_seen) |=> (armed_q || !$past(enable)));
endmodule

// File: rtl/hb_sticky_flag.sv
module hb_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  // set wins over clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= set | (flag & ~clr);
  end
endmodule

// File: rtl/hb_supervisor.sv
module hb_supervisor
  import hb_pkg::*;
#(
  parameter int unsigned SEND_MS    = 400,
  parameter int unsigned TIMEOUT_MS = 1000,
  parameter int unsigned FAST_MS    = 200,
  parameter int unsigned RETRY_MS   = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_1ms,
  input  logic enable,
  input  logic fault_present,
  input  logic hb_detected,
  input  logic flag_clear,
  output logic hb_send_req,
  output logic fault_tone_req,
  output logic timeout_flag,
  output logic too_fast_flag
);
  localparam int unsigned N_FLAGS = 2;

  logic timeout_event;
  logic fast_event;
  logic [N_FLAGS-1:0] flag_set;
  logic [N_FLAGS-1:0] flag_q;

  hb_tx_sched #(.SEND_MS(SEND_MS), .RETRY_MS(RETRY_MS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick_1ms), .enable(enable),
    .fault(fault_present), .send_req(hb_send_req), .tone_req(fault_tone_req)
  );

  hb_rx_monitor #(.TIMEOUT_MS(TIMEOUT_MS), .FAST_MS(FAST_MS)) u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick_1ms), .enable(enable),
    .hb_seen(hb_detected), .timeout_event(timeout_event), .fast_event(fast_event)
  );

  assign flag_set = {fast_event, timeout_event};

  for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
    hb_sticky_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set(flag_set[g]), .clr(flag_clear), .flag(flag_q[g])
    );
  end

  assign timeout_flag  = flag_q[0];
  assign too_fast_flag = flag_q[1];

  assert_timeout_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_flag) |-> $past(timeout_event));
  assert_fast_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fast_event |=> too_fast_flag);
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clear && !timeout_event) |=> !timeout_flag);
  assert_idle_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!hb_send_req && !fault_tone_req));
endmodule

// File: tb/sim_hb_supervisor.sv
`timescale 1ns/1ps
module sim_hb_supervisor;
  localparam int SEND = 400, TOUT = 1000, FAST = 200, RETRY = 50;
  localparam int WATCHDOG = 190000;

  logic clk = 0, rst_n = 0;
  logic tick_1ms = 0, enable = 0, fault_present = 0, hb_detected = 0, flag_clear = 0;
  logic hb_send_req, fault_tone_req, timeout_flag, too_fast_flag;

  int checks = 0, failures = 0, cyc = 0, ph = 0;
  int hb_seen_cnt = 0, ft_seen_cnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hb_supervisor u0 (
    .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms), .enable(enable),
    .fault_present(fault_present), .hb_detected(hb_detected), .flag_clear(flag_clear),
    .hb_send_req(hb_send_req), .fault_tone_req(fault_tone_req),
    .timeout_flag(timeout_flag), .too_fast_flag(too_fast_flag)
  );

  // reference model: elapsed time kept as absolute tick timestamps
  int T, rref, sref, fref, tn;
  bit armed, fq, to_ev, fa_ev, hb_ev, ft_ev;
  logic m_hb, m_ft, m_to, m_fast;

  function automatic bit too_close(bit arm, int elapsed);
    return arm && (elapsed < FAST);
  endfunction

  function automatic bit interval_done(int now, int ref_t, int len);
    return (now - ref_t) == len;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      T = 0; rref = 0; sref = 0; fref = 0; armed = 0; fq = 0;
      m_hb = 0; m_ft = 0; m_to = 0; m_fast = 0;
    end else begin
      tn = T + int'(tick_1ms);
      to_ev = 0; fa_ev = 0; hb_ev = 0; ft_ev = 0;
      if (!enable) begin
        rref = tn; armed = 0;
      end else if (hb_detected) begin
        fa_ev = too_close(armed, T - rref); rref = tn; armed = 1;
      end else if (tick_1ms && interval_done(tn, rref, TOUT)) begin
        to_ev = 1;
      end
      if (!enable || fault_present) sref = tn;
      else if (tick_1ms && interval_done(tn, sref, SEND)) begin hb_ev = 1; sref = tn; end
      if (enable && fault_present && !fq) begin ft_ev = 1; fref = tn; end
      else if (!(enable && fault_present)) fref = tn;
      else if (tick_1ms && interval_done(tn, fref, RETRY)) begin ft_ev = 1; fref = tn; end
      fq = enable && fault_present;
      m_hb = hb_ev; m_ft = ft_ev;
      m_to = to_ev | (m_to & !flag_clear);
      m_fast = fa_ev | (m_fast & !flag_clear);
      T = tn;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // continuous comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 hb_send_req", hb_send_req, m_hb);
      chk("R7 fault_tone_req", fault_tone_req, m_ft);
      chk("R3 timeout_flag", timeout_flag, m_to);
      chk("R4 too_fast_flag", too_fast_flag, m_fast);
      if (hb_send_req === 1'b1) hb_seen_cnt++;
      if (fault_tone_req === 1'b1) ft_seen_cnt++;
    end
  end

  task automatic finish_up();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_up();
    end
  end

  // one cycle: advance tick phase, drop one-cycle strobes
  task automatic step(input int n);
    repeat (n) begin
      @(negedge clk);
      tick_1ms = (ph == 3);
      ph = (ph + 1) % 4;
      hb_detected = 0;
      flag_clear = 0;
    end
  endtask

  task automatic hb_pulse();
    while (tick_1ms) step(1);
    hb_detected = 1;
  endtask

  int b_hb, b_ft;

  initial begin
    void'($urandom(32'd4242));
    // R1: reset state
    step(6);
    chk("R1 hb_send_req", hb_send_req, 1'b0);
    chk("R1 fault_tone_req", fault_tone_req, 1'b0);
    chk("R1 timeout_flag", timeout_flag, 1'b0);
    chk("R1 too_fast_flag", too_fast_flag, 1'b0);
    rst_n = 1;
    step(1);
    chk("R1 outputs after reset", hb_send_req | fault_tone_req | timeout_flag | too_fast_flag, 1'b0);

    // R2, R3: silent link after enable
    enable = 1;
    b_hb = hb_seen_cnt;
    step(4 * 1100);
    chk("R2 two heartbeats in 1100 ticks", 1'(hb_seen_cnt - b_hb == 2), 1'b1);
    chk("R3 timeout after 1000 silent ticks", timeout_flag, 1'b1);
    chk("R5 no too-fast without heartbeats", too_fast_flag, 1'b0);
    flag_clear = 1; step(1);
    chk("R8 clear lowers timeout", timeout_flag, 1'b0);

    // regular heartbeats, first one only arms (R5)
    hb_pulse(); step(1);
    chk("R5 first heartbeat not too fast", too_fast_flag, 1'b0);
    step(4 * 300 - 1); hb_detected = 1;
    step(4 * 300); hb_detected = 1;
    step(1);
    chk("R3 no timeout with 300-tick spacing", timeout_flag, 1'b0);
    chk("R4 300-tick spacing accepted", too_fast_flag, 1'b0);

    // R4 boundary: 199 ticks too fast, 200 ticks accepted
    step(4 * 199 - 1); hb_detected = 1;
    step(1);
    chk("R4 199-tick spacing flagged", too_fast_flag, 1'b1);
    flag_clear = 1; step(1);
    chk("R8 clear lowers too-fast", too_fast_flag, 1'b0);
    step(4 * 200 - 2); hb_detected = 1;
    step(1);
    chk("R4 200-tick spacing accepted", too_fast_flag, 1'b0);

    // R8: set and clear in the same cycle
    step(4 * 10 - 1); hb_detected = 1; flag_clear = 1;
    step(1);
    chk("R8 set wins over clear", too_fast_flag, 1'b1);

    // R6, R7: fault episode
    b_hb = hb_seen_cnt; b_ft = ft_seen_cnt;
    fault_present = 1;
    step(4 * 130);
    chk("R7 three fault tones in 130 ticks", 1'(ft_seen_cnt - b_ft == 3), 1'b1);
    chk("R6 no heartbeat during fault", 1'(hb_seen_cnt - b_hb == 0), 1'b1);
    fault_present = 0;
    b_hb = hb_seen_cnt; b_ft = ft_seen_cnt;
    step(4 * 399 - 4);
    chk("R6 send interval restarted on release", 1'(hb_seen_cnt - b_hb == 0), 1'b1);
    step(4 * 11);
    chk("R6 heartbeat resumes 400 ticks after release", 1'(hb_seen_cnt - b_hb == 1), 1'b1);
    chk("R7 no tone after release", 1'(ft_seen_cnt - b_ft == 0), 1'b1);

    // R9: disabled supervisor
    enable = 0;
    b_hb = hb_seen_cnt; b_ft = ft_seen_cnt;
    fault_present = 1;
    step(4 * 500);
    fault_present = 0;
    chk("R9 no requests while disabled", 1'(hb_seen_cnt == b_hb && ft_seen_cnt == b_ft), 1'b1);
    chk("R9 flag kept while disabled", too_fast_flag, 1'b1);
    flag_clear = 1; step(1);
    enable = 1;
    step(4 * 50);
    hb_pulse(); step(1);
    chk("R5 first heartbeat after re-enable not too fast", too_fast_flag, 1'b0);

    // R10: long gap, single timeout
    step(4 * 1010);
    chk("R3 timeout on long gap", timeout_flag, 1'b1);
    flag_clear = 1; step(1);
    step(4 * 2500);
    chk("R10 no second timeout in the same gap", timeout_flag, 1'b0);

    // constrained random traffic checked by the model
    for (int i = 0; i < 24000; i++) begin
      step(1);
      if ($urandom_range(0, 399) == 0) hb_detected = 1;
      if ($urandom_range(0, 2999) == 0) fault_present = ~fault_present;
      if ($urandom_range(0, 999) == 0) flag_clear = 1;
      if ($urandom_range(0, 7999) == 0) enable = ~enable;
    end
    step(2);
    finish_up();
  end
endmodule